// File: doc/BRIEF.md
# SMBus Write-Only DAC Slave Front End

This block is the receive side of a serial two-wire control port for a 10-bit DAC. Both bus lines are oversampled with the system clock, passed through a synchronizer, and watched for edges. From these the block detects bus start and stop conditions and shifts in one bit on every rising clock edge. It answers two addresses. The first is its own, made of a fixed upper nibble and three strap pins. The second is a broadcast sync address shared with other devices. On its own address it acknowledges by pulling the data line low, and it never drives data back to the master.

Three transaction shapes are decoded. A bare address followed by a stop is a quick command. Address plus one byte is a command-only write. Address plus three bytes is a full word write: a command byte, then the low eight data bits, then a byte whose two lowest bits are the top data bits. Accepted bytes leave the block as held registers with single-cycle valid strobes. A stop strobe and a sync strobe, which carries the sync-or-clear flag, go to a separate update controller that owns the DAC latches.

If a start or stop cuts a word write short, the part already received is kept or dropped according to where the cut came.

Top module: `smb_dac_slave`

## Requirements
- R1: A falling data line while the clock is high is a start, and a rising data line while the clock is high is a stop. Every stop produces exactly one `stop_seen_o` pulse.
- R2: An address byte, sent MSB first, whose upper seven bits equal `0100` followed by `addr_pins_i[2:0]`, and whose eighth bit is 0, is acknowledged. `sda_pull_o` is 1 throughout the high phase of the ninth clock, and it rises only while the clock is low.
- R3: Our own address with the eighth bit 1 (read) is not acknowledged. The rest of that transaction produces no strobe and never pulls the data line.
- R4: An address that matches neither address is not acknowledged, and the block ignores the bus until the next start. A valid transaction after that start is served normally.
- R5: The sync address `1111110` is acknowledged whatever its eighth bit is. `sync_ack_o` pulses once, while the ninth clock is high, and `sync_flag_o` carries the eighth bit. At most one of `cmd_valid_o`, `data_valid_o` and `sync_ack_o` is high in any cycle.
- R6: The byte after our own write address is the command. After its acknowledge, `cmd_o` holds it and `cmd_valid_o` pulses once. `cmd_o` changes only together with that pulse.
- R7: The next two bytes are the low data byte (D7..D0) and the high data byte. After the fourth acknowledge, `data_lo_o` takes the low byte and `data_hi_o` takes bits 1:0 of the high byte, and `data_valid_o` pulses once. Bits 7:2 of the high byte are ignored, and the data outputs change only together with that pulse.
- R8: A start or stop after the command acknowledge but before the high-byte acknowledge keeps the new command, leaves the data outputs unchanged and produces no `data_valid_o`.
- R9: A start or stop before the command acknowledge leaves `cmd_o` unchanged and produces no `cmd_valid_o`.
- R10: Bytes after the fourth byte of a transaction are not acknowledged and change no output.
- R11: A quick command (our own write address and then a stop) is acknowledged and produces only the stop pulse.
- R12: After reset all data outputs are 0, every strobe is low, and `sda_pull_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 16 times the bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| addr_pins_i | input | 3 | Strap inputs for the low address bits |
| sda_pull_o | output | 1 | 1 = pull the data line low (open-drain acknowledge) |
| cmd_o | output | 8 | Last accepted command byte |
| cmd_valid_o | output | 1 | One-cycle pulse when `cmd_o` is loaded |
| data_lo_o | output | 8 | DAC code bits 7:0 |
| data_hi_o | output | 2 | DAC code bits 9:8 |
| data_valid_o | output | 1 | One-cycle pulse when the data outputs are loaded |
| stop_seen_o | output | 1 | One-cycle pulse on each stop condition |
| sync_ack_o | output | 1 | One-cycle pulse when the sync address is acknowledged |
| sync_flag_o | output | 1 | Eighth bit of the sync address, valid with `sync_ack_o` |

## Verification
A wrong byte counter or address decision shows first on the bus. An acknowledge is missing, is extra, or comes in the wrong slot, and the master sees this within the ninth clock of the byte in question. A lost or wrong pending low byte, or a bad interrupt rule, only shows when the word completes or is cut off, as stale or early values on the data outputs or a strobe count that is off by one. For that reason every transaction is followed by a comparison of all held outputs and of the strobe counts.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int PIN_W  = 3;
  localparam int HI_W   = 2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_BITS, PH_PRE_ACK, PH_ACK, PH_ACK_END, PH_SKIP
  } phase_e;

  typedef enum logic [1:0] {TGT_NONE, TGT_OWN, TGT_SYNC} tgt_e;
endpackage

// File: rtl/smb_line_cond.sv
module smb_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin scl_pipe <= '1; sda_pipe <= '1; end
        else begin scl_pipe <= scl_i; sda_pipe <= sda_i; end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) begin scl_pipe <= '1; sda_pipe <= '1; end
        else begin
          scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin scl_q <= 1'b1; sda_q <= 1'b1; end
    else begin scl_q <= scl_o; sda_q <= sda_o; end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/smb_rx_engine.sv
module smb_rx_engine
  import smb_pkg::*;
#(
  parameter logic [ADDR_W-1:0] SYNC_ADDR = 7'b1111110
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_s_i,
  input  logic              sda_s_i,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic [ADDR_W-1:0] own_addr_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              cmd_ev_o,
  output logic              lo_ev_o,
  output logic              word_ev_o,
  output logic              sync_ev_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [1:0] LAST_IDX = 2'd3;

  phase_e             phase_q;
  tgt_e               tgt_q, tgt_d;
  logic [CNT_W-1:0]   cnt_q;
  logic [BYTE_W-1:0]  shreg_q, nxt_byte;
  logic [1:0]         idx_q;
  logic               accept_q, acc_d, pull_q;

  assign nxt_byte = {shreg_q[BYTE_W-2:0], sda_s_i};

  always_comb begin
    if (nxt_byte[BYTE_W-1:1] == own_addr_i && !nxt_byte[0]) tgt_d = TGT_OWN;
    else if (nxt_byte[BYTE_W-1:1] == SYNC_ADDR)              tgt_d = TGT_SYNC;
    else                                                     tgt_d = TGT_NONE;
    acc_d = (idx_q == 2'd0) ? (tgt_d != TGT_NONE) : (tgt_q == TGT_OWN);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE; tgt_q <= TGT_NONE; cnt_q <= '0; shreg_q <= '0;
      idx_q <= '0; accept_q <= 1'b0; pull_q <= 1'b0;
      cmd_ev_o <= 1'b0; lo_ev_o <= 1'b0; word_ev_o <= 1'b0; sync_ev_o <= 1'b0;
    end else begin
      cmd_ev_o <= 1'b0; lo_ev_o <= 1'b0; word_ev_o <= 1'b0; sync_ev_o <= 1'b0;
      if (start_i) begin
        phase_q <= PH_BITS; tgt_q <= TGT_NONE; cnt_q <= '0;
        idx_q <= '0; accept_q <= 1'b0; pull_q <= 1'b0;
      end else if (stop_i) begin
        phase_q <= PH_IDLE; pull_q <= 1'b0;
      end else begin
        case (phase_q)
          PH_BITS: if (scl_rise_i) begin
            shreg_q <= nxt_byte;
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              phase_q  <= PH_PRE_ACK;
              accept_q <= acc_d;
              if (idx_q == 2'd0) tgt_q <= tgt_d;
            end else cnt_q <= cnt_q + 1'b1;
          end
          PH_PRE_ACK: if (scl_fall_i) begin
            pull_q  <= accept_q;
            phase_q <= PH_ACK;
          end
          PH_ACK: if (scl_rise_i) begin
            phase_q <= PH_ACK_END;
            if (accept_q) begin
              sync_ev_o <= (tgt_q == TGT_SYNC);
              cmd_ev_o  <= (tgt_q == TGT_OWN) && (idx_q == 2'd1);
              lo_ev_o   <= (tgt_q == TGT_OWN) && (idx_q == 2'd2);
              word_ev_o <= (tgt_q == TGT_OWN) && (idx_q == LAST_IDX);
            end
          end
          PH_ACK_END: if (scl_fall_i) begin
            pull_q <= 1'b0;
            cnt_q  <= '0;
            if (accept_q && tgt_q == TGT_OWN && idx_q != LAST_IDX) begin
              idx_q   <= idx_q + 1'b1;
              phase_q <= PH_BITS;
            end else phase_q <= PH_SKIP;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_pull_o = pull_q;
  assign byte_o     = shreg_q;

  // R2: acknowledge pull only begins in a clock-low phase
  a_r2_pull_starts_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_q) |-> !scl_s_i);
  // R3: never pull unless an address was taken
  a_r3_pull_needs_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pull_q |-> tgt_q != TGT_NONE);
endmodule

// File: rtl/smb_word_regs.sv
module smb_word_regs
  import smb_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              cmd_ev_i,
  input  logic              lo_ev_i,
  input  logic              word_ev_i,
  input  logic              sync_ev_i,
  input  logic              stop_i,
  output logic [BYTE_W-1:0] cmd_o,
  output logic              cmd_valid_o,
  output logic [BYTE_W-1:0] data_lo_o,
  output logic [HI_W-1:0]   data_hi_o,
  output logic              data_valid_o,
  output logic              stop_seen_o,
  output logic              sync_ack_o,
  output logic              sync_flag_o
);
  logic [BYTE_W-1:0] lo_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o <= '0; data_lo_o <= '0; data_hi_o <= '0; lo_pend_q <= '0;
      cmd_valid_o <= 1'b0; data_valid_o <= 1'b0; stop_seen_o <= 1'b0;
      sync_ack_o <= 1'b0; sync_flag_o <= 1'b0;
    end else begin
      cmd_valid_o  <= cmd_ev_i;
      data_valid_o <= word_ev_i;
      stop_seen_o  <= stop_i;
      sync_ack_o   <= sync_ev_i;
      if (cmd_ev_i)  cmd_o <= byte_i;
      if (lo_ev_i)   lo_pend_q <= byte_i;
      if (word_ev_i) begin
        data_lo_o <= lo_pend_q;
        data_hi_o <= byte_i[HI_W-1:0];
      end
      if (sync_ev_i) sync_flag_o <= byte_i[0];
    end
  end

  a_r5_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_valid_o, data_valid_o, sync_ack_o}));
  a_r6_cmd_moves_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> cmd_valid_o);
  a_r7_data_moves_with_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({data_hi_o, data_lo_o}) |-> data_valid_o);
endmodule

// File: rtl/smb_dac_slave.sv
module smb_dac_slave
  import smb_pkg::*;
#(
  parameter int                      SYNC_STAGES = 2,
  parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI     = 4'b0100,
  parameter logic [ADDR_W-1:0]       SYNC_ADDR   = 7'b1111110
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  input  logic [2:0]       addr_pins_i,
  output logic             sda_pull_o,
  output logic [7:0]       cmd_o,
  output logic             cmd_valid_o,
  output logic [7:0]       data_lo_o,
  output logic [1:0]       data_hi_o,
  output logic             data_valid_o,
  output logic             stop_seen_o,
  output logic             sync_ack_o,
  output logic             sync_flag_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic cmd_ev, lo_ev, word_ev, sync_ev;
  logic [BYTE_W-1:0] rx_byte;

  smb_line_cond #(.STAGES(SYNC_STAGES)) u_line (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  smb_rx_engine #(.SYNC_ADDR(SYNC_ADDR)) u_eng (
    .clk_i, .rst_ni, .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det),
    .own_addr_i({ADDR_HI, addr_pins_i}),
    .sda_pull_o, .byte_o(rx_byte),
    .cmd_ev_o(cmd_ev), .lo_ev_o(lo_ev), .word_ev_o(word_ev), .sync_ev_o(sync_ev)
  );

  smb_word_regs u_regs (
    .clk_i, .rst_ni, .byte_i(rx_byte),
    .cmd_ev_i(cmd_ev), .lo_ev_i(lo_ev), .word_ev_i(word_ev), .sync_ev_i(sync_ev),
    .stop_i(stop_det),
    .cmd_o, .cmd_valid_o, .data_lo_o, .data_hi_o, .data_valid_o,
    .stop_seen_o, .sync_ack_o, .sync_flag_o
  );

  // R6: command strobe follows a bus clock rising edge through two registers
  a_r6_cmd_after_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> $past(scl_rise, 2));
  // R1: stop strobe only one cycle after a detected stop
  a_r1_stop_after_detect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_seen_o |-> $past(stop_det));
endmodule

// File: tb/tb_smb_dac_slave.sv
module tb_smb_dac_slave;
  localparam int Q = 8;

  logic clk = 0, rst_n = 0;
  logic m_scl = 1, m_sda = 1;
  logic [2:0] pins = 3'b101;
  logic sda_bus;
  logic sda_pull, cmd_valid, data_valid, stop_seen, sync_ack, sync_flag;
  logic [7:0] cmd, data_lo;
  logic [1:0] data_hi;

  int total = 0, bad = 0;
  int n_cmd = 0, n_data = 0, n_stop = 0, n_sync = 0;
  int e_cmd = 0, e_data = 0, e_stop = 0, e_sync = 0;
  logic last_flag = 0, sync_scl_hi = 0;
  logic [7:0] x_cmd = 0, x_lo = 0;
  logic [1:0] x_hi = 0;
  bit done = 0;

  always #2 clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  smb_dac_slave dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
    .addr_pins_i(pins), .sda_pull_o(sda_pull), .cmd_o(cmd), .cmd_valid_o(cmd_valid),
    .data_lo_o(data_lo), .data_hi_o(data_hi), .data_valid_o(data_valid),
    .stop_seen_o(stop_seen), .sync_ack_o(sync_ack), .sync_flag_o(sync_flag)
  );

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid) n_cmd++;
    if (data_valid) n_data++;
    if (stop_seen) n_stop++;
    if (sync_ack) begin n_sync++; last_flag = sync_flag; sync_scl_hi = m_scl; end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(int n = 1);
    repeat (n * Q) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    m_sda = 1; wq(); m_scl = 1; wq(); m_sda = 0; wq(); m_scl = 0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 0; wq(); m_scl = 1; wq(); m_sda = 1; wq(2);
    e_stop++;
  endtask

  task automatic send_bit(bit b);
    m_sda = b; wq(); m_scl = 1; wq(2); m_scl = 0; wq();
  endtask

  task automatic send_byte(logic [7:0] v, output bit ack);
    bit seen_hi;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    m_sda = 1; wq(); m_scl = 1; wq();
    seen_hi = sda_pull;
    ack = seen_hi && (sda_bus == 1'b0);
    wq(); m_scl = 0; wq();
  endtask

  function automatic logic [7:0] own_addr(logic [2:0] p, bit rd);
    return {4'b0100, p, rd};
  endfunction

  task automatic check_state(string req);
    check({req, " cmd_o"}, cmd, x_cmd);
    check({req, " data_lo_o"}, data_lo, x_lo);
    check({req, " data_hi_o"}, data_hi, x_hi);
    check({req, " cmd strobes"}, n_cmd, e_cmd);
    check({req, " data strobes"}, n_data, e_data);
    check({req, " stop strobes"}, n_stop, e_stop);
    check({req, " sync strobes"}, n_sync, e_sync);
  endtask

  initial begin
    bit a;
    int kind;
    logic [7:0] c, lo, hi;
    void'($urandom(32'h5eed_1663));
    repeat (5) @(posedge clk);
    #1;
    // R12 reset state
    check("R12 pull in reset", sda_pull, 0);
    check("R12 cmd in reset", cmd, 0);
    rst_n = 1; wq(2);
    check("R12 data after reset", {data_hi, data_lo}, 0);
    check("R12 pull after reset", sda_pull, 0);

    // R11 quick command
    bus_start(); send_byte(own_addr(pins, 0), a);
    check("R2 own write addr ack", a, 1);
    bus_stop();
    check_state("R11 quick");

    // R6 send byte
    bus_start(); send_byte(own_addr(pins, 0), a); send_byte(8'h5A, a);
    check("R6 cmd ack", a, 1);
    bus_stop(); x_cmd = 8'h5A; e_cmd++;
    check_state("R6 send byte");

    // R7 write word with upper bits of high byte set, plus R10 extra byte
    bus_start(); send_byte(own_addr(pins, 0), a); send_byte(8'h03, a);
    send_byte(8'hC3, a); send_byte(8'hFE, a);
    check("R7 high byte ack", a, 1);
    send_byte(8'h01, a);
    check("R10 fifth byte no ack", a, 0);
    bus_stop(); x_cmd = 8'h03; e_cmd++; x_lo = 8'hC3; x_hi = 2'b10; e_data++;
    check_state("R7 R10 word");

    // R3 read to own address
    bus_start(); send_byte(own_addr(pins, 1), a);
    check("R3 read no ack", a, 0);
    send_byte(8'h77, a);
    check("R3 following byte no ack", a, 0);
    bus_stop();
    check_state("R3 read");

    // R4 mismatch, then repeated start with a good write
    bus_start(); send_byte(own_addr(pins ^ 3'b001, 0), a);
    check("R4 mismatch no ack", a, 0);
    send_byte(8'h11, a);
    check("R4 ignored byte no ack", a, 0);
    bus_start(); send_byte(own_addr(pins, 0), a); send_byte(8'h99, a);
    check("R4 recovered ack", a, 1);
    bus_stop(); x_cmd = 8'h99; e_cmd++;
    check_state("R4 recovery");

    // R5 sync address, both flag values
    for (int f = 0; f < 2; f++) begin
      bus_start(); send_byte({7'b1111110, f[0]}, a);
      check("R5 sync ack", a, 1);
      bus_stop(); e_sync++;
      check("R5 sync flag", last_flag, f[0]);
      check("R5 sync during clock high", sync_scl_hi, 1);
      check_state("R5 sync");
    end

    // R9 cut inside the command byte
    bus_start(); send_byte(own_addr(pins, 0), a);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    bus_stop();
    check_state("R9 partial cmd");

    // R8 cut after low byte by repeated start
    bus_start(); send_byte(own_addr(pins, 0), a); send_byte(8'h42, a);
    send_byte(8'hAA, a); bus_start(); bus_stop();
    x_cmd = 8'h42; e_cmd++;
    check_state("R8 cut after low");

    // constrained random mix
    for (int it = 0; it < 24; it++) begin
      pins = 3'($urandom_range(0, 7));
      kind = $urandom_range(0, 4);
      c = 8'($urandom); lo = 8'($urandom); hi = 8'($urandom);
      bus_start(); send_byte(own_addr(pins, 0), a);
      check("R2 random addr ack", a, 1);
      if (kind == 4) begin
        for (int i = 0; i < 3; i++) send_bit(c[7 - i]);
      end else if (kind >= 1) begin
        send_byte(c, a); x_cmd = c; e_cmd++;
        if (kind >= 2) send_byte(lo, a);
        if (kind == 2) begin send_byte(hi, a); x_lo = lo; x_hi = hi[1:0]; e_data++; end
      end
      if (kind == 3 && $urandom_range(0, 1) == 1) bus_start();
      bus_stop();
      check_state(kind == 4 ? "R9 random" : kind == 3 ? "R8 random" :
                  kind == 2 ? "R7 random" : kind == 1 ? "R6 random" : "R11 random");
      check("R1 bus idle pull", sda_pull, 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule